// File: doc/BRIEF.md
# DTMF Steering and Guard-Time Controller

This block sits behind a dual-tone frequency detector and turns its raw "tone pair present" indication into a clean, debounced registration of a key code. Counters replace the external resistor–capacitor timing network that a receiver would otherwise need. A code is accepted only after the detector's flag has stayed asserted for a programmable presence guard. The accepted code goes into an output latch. After a fixed settling interval, a steered flag rises to tell the host that a new code waits on the bus. The steered flag is released only after the detector's flag has stayed low for a programmable absence guard. As a result, short dropouts inside a tone are ignored, and tones that are too short are rejected.

Both guard thresholds are clock-cycle counts. They are sampled only while the controller is idle, so reprogramming them during a tone has no effect on that tone. To meet the usual telephony rule (accept 40 ms or longer, reject 20 ms or shorter, for both tones and pauses), set each threshold to a cycle count between those two durations at the system clock rate. The latched code is presented on a three-state-style bus: a data vector plus a pad drive enable that follows the output-enable input. The one-cycle registration pulse is a plain event with no ready. Downstream logic must take it in the cycle it appears, because it cannot be held off.

Top module: `dtmf_steer_ctrl`

## Requirements
- R1: During and after reset, `steered_o` and `reg_pulse_o` are 0 and the latched code is 0.
- R2: If `pair_seen_i` is sampled high on P+1 consecutive rising edges E0..EP, where E0 is the first such edge in idle and P is the presence threshold, then the code on `tone_code_i` at EP is latched, and `reg_pulse_o` is 1 for exactly the one cycle after EP.
- R3: If `pair_seen_i` is sampled low before EP, no code is latched, no pulse is given and `steered_o` stays 0. The presence count restarts, so the next rise again needs P+1 high samples.
- R4: `steered_o` rises on the 16th rising edge after the latching edge, so the code is on the bus 16 cycles before the flag.
- R5: While steered and while `pair_seen_i` stays high, `steered_o` stays 1 and changes on `tone_code_i` do not alter the latched code.
- R6: Once steered, if `pair_seen_i` is sampled low on A+1 consecutive edges F0..FA (A is the absence threshold), `steered_o` falls at FA.
- R7: A dropout that ends before FA leaves `steered_o` at 1 and the code unchanged, and gives no pulse. The absence count restarts on each return high.
- R8: The latched code stays on the bus after release until the next registration replaces it.
- R9: When `out_en_i` is 1, `code_o` shows the latched code and `code_oe_o` is 1. When `out_en_i` is 0, `code_o` is 0 and `code_oe_o` is 0. The enable never changes the latch contents, including for a code registered while it was 0.
- R10: Thresholds are taken from `present_cycles_i` and `absent_cycles_i` only while idle (including E0). Values changed during a tone apply to the next tone.
- R11: A threshold of 0 behaves as 1: the latch happens at E1 and the release at F1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_seen_i | input | 1 | Detector flag: a valid tone pair is present |
| tone_code_i | input | CODE_W | Code of the detected tone pair |
| present_cycles_i | input | GUARD_W | Presence guard threshold in cycles |
| absent_cycles_i | input | GUARD_W | Absence guard threshold in cycles |
| out_en_i | input | 1 | Bus output enable |
| code_o | output | CODE_W | Latched code, 0 when not enabled |
| code_oe_o | output | 1 | Pad drive enable for the code bus |
| steered_o | output | 1 | Delayed steered flag |
| reg_pulse_o | output | 1 | One-cycle pulse when a new code is latched |

## Verification
On every cycle, the assertions check the following: the registration pulse lasts one cycle; the latch changes only together with that pulse; a pulse follows a sampled-high flag while not steered; the steered flag rises exactly 16 cycles after a pulse; and it falls only after a low flag sample. The exact guard lengths, the restart of the counts after a glitch or dropout, the threshold sampling window and the enable gating depend on the programmed inputs. The bench's directed scenarios show these by counting edges from a known start.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;
  localparam int CODE_W_DEF     = 4;
  localparam int GUARD_W_DEF    = 24;
  localparam int SETTLE_CYC_DEF = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_SETTLE,
    ST_HELD,
    ST_REL
  } steer_state_e;
endpackage

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         advance,
  input  logic [W-1:0] thr,
  output logic         reached
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (start)                    cnt_q <= W'(1);
    else if (advance && cnt_q != '1)   cnt_q <= cnt_q + W'(1);
  end

  assign reached = (cnt_q >= thr);
endmodule

// File: rtl/dtmf_settle_timer.sv
module dtmf_settle_timer #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + CW'(1);
    else          cnt_q <= '0;
  end

  assign done = run && (cnt_q == CW'(CYC - 1));
endmodule

// File: rtl/dtmf_code_latch.sv
module dtmf_code_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] code_in,
  input  logic         out_en,
  output logic [W-1:0] code_q,
  output logic [W-1:0] bus,
  output logic         bus_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n)    code_q <= '0;
    else if (load) code_q <= code_in;
  end

  assign bus    = out_en ? code_q : '0;
  assign bus_oe = out_en;
endmodule

// File: rtl/dtmf_steer_ctrl.sv
module dtmf_steer_ctrl
  import dtmf_steer_pkg::*;
#(
  parameter int CODE_W     = CODE_W_DEF,
  parameter int GUARD_W    = GUARD_W_DEF,
  parameter int SETTLE_CYC = SETTLE_CYC_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pair_seen_i,
  input  logic [CODE_W-1:0]  tone_code_i,
  input  logic [GUARD_W-1:0] present_cycles_i,
  input  logic [GUARD_W-1:0] absent_cycles_i,
  input  logic               out_en_i,
  output logic [CODE_W-1:0]  code_o,
  output logic               code_oe_o,
  output logic               steered_o,
  output logic               reg_pulse_o
);
  steer_state_e       state_q, state_d;
  logic [GUARD_W-1:0] pres_thr_q, abs_thr_q, thr_sel;
  logic               gt_start, gt_adv, gt_reached;
  logic               settle_done, load;
  logic               pulse_q;
  logic [CODE_W-1:0]  code_q;

  // thresholds follow the inputs only while idle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_thr_q <= '0;
      abs_thr_q  <= '0;
    end else if (state_q == ST_IDLE) begin
      pres_thr_q <= present_cycles_i;
      abs_thr_q  <= absent_cycles_i;
    end
  end

  assign thr_sel = (state_q == ST_REL) ? abs_thr_q : pres_thr_q;

  dtmf_guard_timer #(.W(GUARD_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .start(gt_start), .advance(gt_adv),
    .thr(thr_sel), .reached(gt_reached)
  );

  dtmf_settle_timer #(.CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_SETTLE), .done(settle_done)
  );

  dtmf_code_latch #(.W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(load), .code_in(tone_code_i),
    .out_en(out_en_i), .code_q(code_q), .bus(code_o), .bus_oe(code_oe_o)
  );

  always_comb begin
    state_d  = state_q;
    gt_start = 1'b0;
    gt_adv   = 1'b0;
    load     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (pair_seen_i) begin
        state_d  = ST_ACQ;
        gt_start = 1'b1;
      end
      ST_ACQ: begin
        if (!pair_seen_i)    state_d = ST_IDLE;
        else if (gt_reached) begin
          state_d = ST_SETTLE;
          load    = 1'b1;
        end else             gt_adv  = 1'b1;
      end
      ST_SETTLE: if (settle_done) state_d = ST_HELD;
      ST_HELD: if (!pair_seen_i) begin
        state_d  = ST_REL;
        gt_start = 1'b1;
      end
      ST_REL: begin
        if (pair_seen_i)     state_d = ST_HELD;
        else if (gt_reached) state_d = ST_IDLE;
        else                 gt_adv  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= load;
    end
  end

  assign steered_o   = (state_q == ST_HELD) || (state_q == ST_REL);
  assign reg_pulse_o = pulse_q;
endmodule

// File: rtl/dtmf_steer_checker.sv
module dtmf_steer_checker #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pair_seen_i,
  input logic              steered_o,
  input logic              reg_pulse_o,
  input logic [CODE_W-1:0] latch_q
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_pulse_o |=> !reg_pulse_o); // R2
  AST_LATCH_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_pulse_o |-> latch_q == $past(latch_q)); // R5
  AST_PULSE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    reg_pulse_o |-> $past(pair_seen_i) && !$past(steered_o)); // R3
  AST_RISE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steered_o) |-> $past(reg_pulse_o, 16)); // R4
  AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(steered_o) |-> !$past(pair_seen_i)); // R6
  AST_NO_PULSE_WHILE_STEERED: assert property (@(posedge clk) disable iff (!rst_n)
    steered_o |-> !reg_pulse_o); // R5
endmodule

bind dtmf_steer_ctrl dtmf_steer_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pair_seen_i(pair_seen_i),
  .steered_o(steered_o), .reg_pulse_o(reg_pulse_o), .latch_q(code_q)
);

// File: tb/dtmf_steer_ctrl_bench.sv
module dtmf_steer_ctrl_bench;
  localparam int P = 20;
  localparam int A = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pair_seen = 1'b0;
  logic [3:0]  tone_code = 4'h0;
  logic [23:0] pres_cyc = 24'(P);
  logic [23:0] abs_cyc = 24'(A);
  logic        out_en = 1'b1;
  logic [3:0]  code_o;
  logic        code_oe_o, steered_o, reg_pulse_o;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dtmf_steer_ctrl u_dtmf_steer_ctrl (
    .clk(clk), .rst_n(rst_n), .pair_seen_i(pair_seen), .tone_code_i(tone_code),
    .present_cycles_i(pres_cyc), .absent_cycles_i(abs_cyc), .out_en_i(out_en),
    .code_o(code_o), .code_oe_o(code_oe_o), .steered_o(steered_o),
    .reg_pulse_o(reg_pulse_o)
  );

  always @(negedge clk) if (rst_n && reg_pulse_o) pulses++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // from idle: raise flag with code c and wait until steered
  task automatic tone_on(logic [3:0] c);
    pair_seen = 1'b1; tone_code = c;
    step(P + 17);
  endtask

  task automatic tone_off();
    pair_seen = 1'b0;
    step(A + 2);
  endtask

  task automatic t_reset();
    chk("R1 steered", steered_o, 0);
    chk("R1 pulse", reg_pulse_o, 0);
    chk("R1 code", code_o, 0);
  endtask

  task automatic t_register();
    pair_seen = 1'b1; tone_code = 4'h5;
    step(P);
    chk("R2 no latch before EP", code_o, 0);
    chk("R2 no pulse before EP", reg_pulse_o, 0);
    step(1);
    chk("R2 pulse", reg_pulse_o, 1);
    chk("R2 code", code_o, 5);
    step(1);
    chk("R2 pulse width", reg_pulse_o, 0);
    step(14);
    chk("R4 not yet steered", steered_o, 0);
    step(1);
    chk("R4 steered", steered_o, 1);
    tone_code = 4'h9;
    step(30);
    chk("R5 held", steered_o, 1);
    chk("R5 code unchanged", code_o, 5);
    pair_seen = 1'b0;
    step(A);
    chk("R6 still steered", steered_o, 1);
    step(1);
    chk("R6 released", steered_o, 0);
    chk("R8 code held", code_o, 5);
    step(1);
  endtask

  task automatic t_short();
    int p0 = pulses;
    pair_seen = 1'b1; tone_code = 4'h7;
    step(P);
    pair_seen = 1'b0;
    step(40);
    chk("R3 short tone no pulse", pulses - p0, 0);
    chk("R3 short tone no steer", steered_o, 0);
    chk("R8 code kept", code_o, 5);
    pair_seen = 1'b1; tone_code = 4'h3;
    step(15);
    pair_seen = 1'b0;
    step(1);
    pair_seen = 1'b1;
    step(P);
    chk("R3 count restarted", reg_pulse_o, 0);
    step(1);
    chk("R3 latch after restart", reg_pulse_o, 1);
    chk("R8 new code", code_o, 3);
    step(20);
    tone_off();
  endtask

  task automatic t_dropout();
    int p0;
    tone_on(4'hC);
    p0 = pulses;
    chk("R7 steered", steered_o, 1);
    pair_seen = 1'b0; step(A); pair_seen = 1'b1;
    step(5);
    chk("R7 first dropout", steered_o, 1);
    pair_seen = 1'b0; step(A); pair_seen = 1'b1;
    step(5);
    chk("R7 second dropout", steered_o, 1);
    chk("R7 code", code_o, 12);
    chk("R7 no pulse", pulses - p0, 0);
    tone_off();
    chk("R6 released after dropouts", steered_o, 0);
  endtask

  task automatic t_enable();
    out_en = 1'b0;
    step(1);
    chk("R9 bus off", code_o, 0);
    chk("R9 oe off", code_oe_o, 0);
    out_en = 1'b1;
    step(1);
    chk("R9 bus back", code_o, 12);
    chk("R9 oe on", code_oe_o, 1);
    out_en = 1'b0;
    tone_on(4'hA);
    chk("R9 bus off during tone", code_o, 0);
    tone_off();
    out_en = 1'b1;
    step(1);
    chk("R9 code latched while off", code_o, 10);
  endtask

  task automatic t_sample();
    pair_seen = 1'b1; tone_code = 4'h6;
    step(3);
    pres_cyc = 24'd2;
    step(P - 3);
    chk("R10 old presence kept", reg_pulse_o, 0);
    step(1);
    chk("R10 latch at old P", reg_pulse_o, 1);
    abs_cyc = 24'd1;
    step(20);
    pair_seen = 1'b0;
    step(A);
    chk("R10 old absence kept", steered_o, 1);
    step(1);
    chk("R10 release at old A", steered_o, 0);
    step(2);
    pair_seen = 1'b1; tone_code = 4'h2;
    step(2);
    chk("R10 new P not yet", reg_pulse_o, 0);
    step(1);
    chk("R10 new P latch", reg_pulse_o, 1);
    step(20);
    pair_seen = 1'b0;
    step(1);
    chk("R10 new A not yet", steered_o, 1);
    step(1);
    chk("R10 new A release", steered_o, 0);
    step(1);
  endtask

  task automatic t_zero();
    pres_cyc = 24'd0; abs_cyc = 24'd0;
    step(2);
    pair_seen = 1'b1; tone_code = 4'hF;
    step(1);
    chk("R11 no latch at E0", reg_pulse_o, 0);
    step(1);
    chk("R11 latch at E1", reg_pulse_o, 1);
    chk("R11 code", code_o, 15);
    step(20);
    pair_seen = 1'b0;
    step(1);
    chk("R11 hold at F0", steered_o, 1);
    step(1);
    chk("R11 release at F1", steered_o, 0);
    pres_cyc = 24'(P); abs_cyc = 24'(A);
    step(2);
  endtask

  initial begin
    step(4);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_register();
    t_short();
    t_dropout();
    t_enable();
    t_sample();
    t_zero();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule